// File: doc/BRIEF.md
# Right-Justified Audio Serial Transmitter

This block sends a stereo sample stream over a three-wire audio serial link: a bit clock, a channel-select clock and one data line. It makes the bit clock by dividing the system clock. Each frame has a left half and a right half. The length of each half, counted in bit clocks, comes from a rate code. The sample word length comes from a separate word code. Each sample is right-justified in its half-frame, so its last bit falls in the last bit clock of the half-frame. The clocks before it carry zeros.

Samples arrive over one valid/ready port per channel. Each port feeds a one-entry holding register. The holding register is copied into the output shifter when that channel's half-frame begins. If it is empty at that moment, a zero sample goes out. A per-channel empty flag shows the state of each holding register. One interrupt output is raised when any unmasked empty flag is set. Rate, word length and divider settings are taken only when a left half-frame starts, so a frame never mixes two configurations.

Top module: `i2s_rj_tx`

## Requirements
- R1: The bit clock `sck` is high for `cfgDiv+1` system clock cycles and then low for `cfgDiv+1` cycles, so two successive falling edges are `2*(cfgDiv+1)` cycles apart.
- R2: Each half-frame has this many `sck` periods, set by `cfgRate`: 0 gives 16, 1 gives 24, 2 or 3 gives 32. `lrck` is 0 during the left half-frame and 1 during the right half-frame. After reset, the first half-frame is a left one.
- R3: The word length comes from `cfgWord`: 0 gives 16, 1 gives 24, 2 or 3 gives 32. Bits `[W-1:0]` of the sample go out MSB first. Bit 0 is in the last `sck` period of the half-frame. Sample bits above `W-1` are dropped.
- R4: In the leading `slot-W` periods of a half-frame, `sdata` is 0.
- R5: A word length larger than the half-frame length is clamped to the half-frame length, so every period of the half-frame carries sample data.
- R6: `sdata` and `lrck` change only in the cycle where `sck` falls. They hold steady across every rising edge of `sck`.
- R7: `leftReady`/`rightReady` are high only while that channel's holding register is empty. A transfer (valid and ready together) fills the register. The register is emptied when its channel's half-frame starts, and that half-frame sends the stored sample.
- R8: If a channel's holding register is empty when its half-frame starts, the half-frame sends an all-zero sample and the channel's empty flag stays 1.
- R9: `leftEmpty`/`rightEmpty` show that the holding register is empty. `irq` = (`leftEmpty` and `intMask[0]`) or (`rightEmpty` and `intMask[1]`), without delay.
- R10: A change to `cfgRate`, `cfgWord` or `cfgDiv` takes effect from the next left half-frame. A half-frame already under way, and the right half-frame that follows it, keep the old settings.
- R11: After reset, `sck`, `lrck` and `sdata` are 0, both empty flags are 1 and both ready outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgDiv | input | DIV_W | Half-period of the bit clock, minus one |
| cfgRate | input | 2 | Half-frame length code |
| cfgWord | input | 2 | Sample word length code |
| intMask | input | 2 | Interrupt enables: bit 0 left, bit 1 right |
| leftData | input | 32 | Left sample |
| leftValid | input | 1 | Left sample valid |
| leftReady | output | 1 | Left holding register can accept |
| rightData | input | 32 | Right sample |
| rightValid | input | 1 | Right sample valid |
| rightReady | output | 1 | Right holding register can accept |
| sck | output | 1 | Bit clock |
| lrck | output | 1 | Channel select, 0 = left |
| sdata | output | 1 | Serial data |
| leftEmpty | output | 1 | Left holding register empty |
| rightEmpty | output | 1 | Right holding register empty |
| irq | output | 1 | Combined masked empty interrupt |

## Verification
The bench rebuilds each half-frame bit by bit at the falling edges of `sck`. It then compares the bit count and the collected value against the sample, masked to the effective word length. A design that put the data at the start of the half-frame, or got the shift amount wrong, would show non-zero high bits or missing low bits. The clamp cases (16- and 24-clock half-frames with a longer word) catch a design that drops the low bits or overruns into the next half-frame. A directed test changes the rate in the middle of a left half-frame. It expects the right half-frame to keep the old length, which a design that applies the setting at once would break. A starved right channel must give all zeros with its empty flag still set, where a faulty holding register would replay the old sample.

// File: rtl/i2s_rj_pkg.sv
package i2s_rj_pkg;

  localparam int MAX_BITS = 32;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);

  typedef logic [LEN_W-1:0] len_t;

  // Control-to-datapath strobes, valid in the cycle of an sck falling edge.
  typedef struct packed {
    logic emit;     // sck falls in this cycle
    logic load;     // a half-frame starts: take the holding register
    logic chan;     // channel of the bit being emitted (0 = left)
    logic dataBit;  // the bit is sample data, not padding
    len_t wordLen;  // effective word length in force
  } tx_strobe_t;

  function automatic len_t slotFromRate(input logic [1:0] code);
    case (code)
      2'd0:    return len_t'(16);
      2'd1:    return len_t'(24);
      default: return len_t'(32);
    endcase
  endfunction

  function automatic len_t wordFromCode(input logic [1:0] code);
    case (code)
      2'd0:    return len_t'(16);
      2'd1:    return len_t'(24);
      default: return len_t'(32);
    endcase
  endfunction

endpackage

// File: rtl/i2s_rj_ctrl.sv
module i2s_rj_ctrl
  import i2s_rj_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [1:0]       cfgRate,
  input  logic [1:0]       cfgWord,
  output logic             sck,
  output logic             lrck,
  output tx_strobe_t       strobe
);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] activeDiv;
  logic             sckQ;
  logic             lrckQ;
  logic             started;
  len_t             bitIdx;
  len_t             activeSlot;
  len_t             activeWord;

  logic tick;
  logic fall;
  logic slotEnd;
  logic nextChan;
  logic newLeft;
  len_t reqSlot;
  len_t reqWord;
  len_t clampWord;
  len_t slotUse;
  len_t wordUse;
  len_t idxUse;

  always_comb begin
    tick      = (divCnt >= activeDiv);
    fall      = tick && sckQ;
    slotEnd   = !started || (bitIdx == activeSlot - len_t'(1));
    nextChan  = started ? ~lrckQ : 1'b0;
    newLeft   = fall && slotEnd && !nextChan;
    reqSlot   = slotFromRate(cfgRate);
    reqWord   = wordFromCode(cfgWord);
    clampWord = (reqWord > reqSlot) ? reqSlot : reqWord;
    slotUse   = newLeft ? reqSlot   : activeSlot;
    wordUse   = newLeft ? clampWord : activeWord;
    idxUse    = slotEnd ? '0 : bitIdx + len_t'(1);

    strobe.emit    = fall;
    strobe.load    = fall && slotEnd;
    strobe.chan    = slotEnd ? nextChan : lrckQ;
    strobe.dataBit = (idxUse >= (slotUse - wordUse));
    strobe.wordLen = wordUse;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt     <= '0;
      activeDiv  <= '0;
      sckQ       <= 1'b0;
      lrckQ      <= 1'b0;
      started    <= 1'b0;
      bitIdx     <= '0;
      activeSlot <= len_t'(MAX_BITS);
      activeWord <= len_t'(16);
    end else begin
      if (tick) begin
        divCnt <= '0;
        sckQ   <= ~sckQ;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (!started || newLeft) begin
        activeDiv <= cfgDiv;
      end
      if (fall) begin
        started <= 1'b1;
        bitIdx  <= idxUse;
        if (slotEnd) begin
          lrckQ <= nextChan;
        end
      end
      if (newLeft) begin
        activeSlot <= reqSlot;
        activeWord <= clampWord;
      end
    end
  end

  assign sck  = sckQ;
  assign lrck = lrckQ;

  // R2
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (bitIdx < activeSlot));

  // R10
  cfg_left_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(activeSlot) || !$stable(activeWord)) |-> (!lrckQ && $past(fall)));

  // R1
  div_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    started |-> (divCnt <= activeDiv));

  // R5
  word_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeWord <= activeSlot);

endmodule

// File: rtl/i2s_rj_dp.sv
module i2s_rj_dp
  import i2s_rj_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tx_strobe_t          strobe,
  input  logic [MAX_BITS-1:0] leftData,
  input  logic                leftValid,
  output logic                leftReady,
  input  logic [MAX_BITS-1:0] rightData,
  input  logic                rightValid,
  output logic                rightReady,
  input  logic [1:0]          intMask,
  output logic                sdata,
  output logic                leftEmpty,
  output logic                rightEmpty,
  output logic                irq
);

  localparam int NUM_CH = 2;

  logic [MAX_BITS-1:0] inData  [NUM_CH];
  logic                inValid [NUM_CH];
  logic [MAX_BITS-1:0] holdQ   [NUM_CH];
  logic                fullQ   [NUM_CH];

  assign inData[0]  = leftData;
  assign inData[1]  = rightData;
  assign inValid[0] = leftValid;
  assign inValid[1] = rightValid;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_hold
    logic accept;
    logic take;
    assign accept = inValid[ch] && !fullQ[ch];
    assign take   = strobe.load && (strobe.chan == 1'(ch));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        holdQ[ch] <= '0;
        fullQ[ch] <= 1'b0;
      end else if (accept) begin
        holdQ[ch] <= inData[ch];
        fullQ[ch] <= 1'b1;
      end else if (take) begin
        fullQ[ch] <= 1'b0;
      end
    end

    // R7
    accept_fill_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid[ch] && !fullQ[ch]) |=> fullQ[ch]);

    // R8
    starve_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (take && !fullQ[ch] && !inValid[ch]) |=> !fullQ[ch]);
  end

  logic [MAX_BITS-1:0] shQ;
  logic                sdataQ;
  logic [MAX_BITS-1:0] pick;
  logic [MAX_BITS-1:0] aligned;
  logic [MAX_BITS-1:0] nextWord;
  len_t                shAmt;

  always_comb begin
    pick     = fullQ[strobe.chan] ? holdQ[strobe.chan] : '0;
    shAmt    = len_t'(MAX_BITS) - strobe.wordLen;
    aligned  = pick << shAmt;
    nextWord = strobe.load ? aligned : shQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shQ    <= '0;
      sdataQ <= 1'b0;
    end else if (strobe.emit) begin
      if (strobe.dataBit) begin
        sdataQ <= nextWord[MAX_BITS-1];
        shQ    <= nextWord << 1;
      end else begin
        sdataQ <= 1'b0;
        shQ    <= nextWord;
      end
    end
  end

  assign sdata      = sdataQ;
  assign leftReady  = !fullQ[0];
  assign rightReady = !fullQ[1];
  assign leftEmpty  = !fullQ[0];
  assign rightEmpty = !fullQ[1];
  assign irq        = |(intMask & {!fullQ[1], !fullQ[0]});

  // R4
  pad_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.emit && !strobe.dataBit) |=> !sdata);

endmodule

// File: rtl/i2s_rj_tx.sv
module i2s_rj_tx
  import i2s_rj_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DIV_W-1:0]    cfgDiv,
  input  logic [1:0]          cfgRate,
  input  logic [1:0]          cfgWord,
  input  logic [1:0]          intMask,
  input  logic [MAX_BITS-1:0] leftData,
  input  logic                leftValid,
  output logic                leftReady,
  input  logic [MAX_BITS-1:0] rightData,
  input  logic                rightValid,
  output logic                rightReady,
  output logic                sck,
  output logic                lrck,
  output logic                sdata,
  output logic                leftEmpty,
  output logic                rightEmpty,
  output logic                irq
);

  tx_strobe_t strobe;

  i2s_rj_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgDiv  (cfgDiv),
    .cfgRate (cfgRate),
    .cfgWord (cfgWord),
    .sck     (sck),
    .lrck    (lrck),
    .strobe  (strobe)
  );

  i2s_rj_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .leftData   (leftData),
    .leftValid  (leftValid),
    .leftReady  (leftReady),
    .rightData  (rightData),
    .rightValid (rightValid),
    .rightReady (rightReady),
    .intMask    (intMask),
    .sdata      (sdata),
    .leftEmpty  (leftEmpty),
    .rightEmpty (rightEmpty),
    .irq        (irq)
  );

  // R6
  edge_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sck) |-> ($stable(sdata) && $stable(lrck)));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((leftEmpty && intMask[0]) || (rightEmpty && intMask[1])));

endmodule

// File: tb/tb_i2s_rj_tx.sv
module tb_i2s_rj_tx;

  typedef struct packed {
    logic [7:0]  div;
    logic [1:0]  rate;
    logic [1:0]  word;
    logic [31:0] l;
    logic [31:0] r;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{8'd1, 2'd2, 2'd0, 32'hFFFF_A5C3, 32'h0000_1234},
    '{8'd2, 2'd2, 2'd1, 32'h77AB_CDEF, 32'h00FF_0001},
    '{8'd1, 2'd3, 2'd2, 32'h8000_0001, 32'hDEAD_BEEF},
    '{8'd3, 2'd1, 2'd0, 32'h0001_8001, 32'hFFFF_FFFF},
    '{8'd0, 2'd0, 2'd2, 32'h1234_5678, 32'h9ABC_DEF0},
    '{8'd1, 2'd1, 2'd3, 32'hC0FF_EE11, 32'h0055_AA77}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgDiv = 8'd1;
  logic [1:0]  cfgRate = 2'd2;
  logic [1:0]  cfgWord = 2'd0;
  logic [1:0]  intMask = 2'b11;
  logic [31:0] leftData = '0;
  logic        leftValid = 1'b0;
  logic [31:0] rightData = '0;
  logic        rightValid = 1'b0;
  logic        leftReady, rightReady, sck, lrck, sdata, leftEmpty, rightEmpty, irq;

  i2s_rj_tx #(.DIV_W(8)) dut (
    .clk(clk), .rstN(rstN), .cfgDiv(cfgDiv), .cfgRate(cfgRate), .cfgWord(cfgWord),
    .intMask(intMask), .leftData(leftData), .leftValid(leftValid), .leftReady(leftReady),
    .rightData(rightData), .rightValid(rightValid), .rightReady(rightReady),
    .sck(sck), .lrck(lrck), .sdata(sdata), .leftEmpty(leftEmpty),
    .rightEmpty(rightEmpty), .irq(irq)
  );

  always #2.5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lastFallCyc = 0;
  int gap = 0;
  logic curL = 1'b1;
  logic prevL = 1'b1;
  logic sd = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slotOf(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  function automatic int wordOf(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  function automatic logic [31:0] expVal(input logic [31:0] s, input int w);
    return (w >= 32) ? s : (s & ((32'h1 << w) - 32'h1));
  endfunction

  // Wait for the next falling edge of sck, observed at a negative clk edge.
  task automatic waitFall();
    logic p;
    p = sck;
    forever begin
      @(negedge clk);
      if (p && !sck) break;
      p = sck;
    end
    prevL = curL;
    curL  = lrck;
    sd    = sdata;
    gap   = cyc - lastFallCyc;
    lastFallCyc = cyc;
  endtask

  task automatic waitStart(input logic ch);
    do waitFall(); while (!(curL == ch && prevL != ch));
  endtask

  // Current fall carries the first bit of a half-frame; ends on the next half-frame's first fall.
  task automatic captureSlot(output int cnt, output logic [31:0] acc);
    logic ch;
    ch  = curL;
    acc = {31'd0, sd};
    cnt = 1;
    forever begin
      waitFall();
      if (curL != ch) break;
      acc = {acc[30:0], sd};
      cnt++;
    end
  endtask

  task automatic pushLeft(input logic [31:0] d);
    leftData = d;
    leftValid = 1'b1;
    while (!leftReady) @(negedge clk);
    @(negedge clk);
    leftValid = 1'b0;
  endtask

  task automatic pushRight(input logic [31:0] d);
    rightData = d;
    rightValid = 1'b1;
    while (!rightReady) @(negedge clk);
    @(negedge clk);
    rightValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lc, rc, w, s;
    logic [31:0] la, ra;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk(sck == 1'b0 && lrck == 1'b0 && sdata == 1'b0, "R11 pins", {29'd0, sck, lrck, sdata}, 32'd0);
    chk(leftEmpty && rightEmpty && leftReady && rightReady, "R11 flags",
        {28'd0, leftEmpty, rightEmpty, leftReady, rightReady}, 32'hF);
    // R9 masking
    chk(irq == 1'b1, "R9 mask11", {31'd0, irq}, 32'd1);
    intMask = 2'b00; #1;
    chk(irq == 1'b0, "R9 mask00", {31'd0, irq}, 32'd0);
    intMask = 2'b10; #1;
    chk(irq == 1'b1, "R9 mask10", {31'd0, irq}, 32'd1);
    intMask = 2'b11;

    // Main table
    for (int i = 0; i < NV; i++) begin
      waitStart(1'b1);
      cfgDiv  = VECS[i].div;
      cfgRate = VECS[i].rate;
      cfgWord = VECS[i].word;
      pushLeft(VECS[i].l);
      pushRight(VECS[i].r);
      // R7 ready drops once filled
      chk(!leftReady && !rightReady && !leftEmpty && !rightEmpty && !irq, "R7 R9 filled",
          {27'd0, leftReady, rightReady, leftEmpty, rightEmpty, irq}, 32'd0);
      waitStart(1'b0);
      s = slotOf(VECS[i].rate);
      w = wordOf(VECS[i].word);
      if (w > s) w = s;
      // R7 left taken at its half-frame start
      chk(leftEmpty && irq, "R7 left taken", {30'd0, leftEmpty, irq}, 32'd3);
      captureSlot(lc, la);
      // R1 bit clock period
      chk(gap == 2 * (int'(VECS[i].div) + 1), "R1 period", gap, 2 * (int'(VECS[i].div) + 1));
      captureSlot(rc, ra);
      // R2 half-frame length, R3 R4 R5 right-justified content
      chk(lc == s && rc == s, "R2 slot length", lc, s);
      chk(la == expVal(VECS[i].l, w), "R3 R4 R5 left data", la, expVal(VECS[i].l, w));
      chk(ra == expVal(VECS[i].r, w), "R3 R4 R5 right data", ra, expVal(VECS[i].r, w));
    end

    // R8 starved right channel sends zeros and stays empty
    cfgDiv = 8'd1; cfgRate = 2'd2; cfgWord = 2'd2;
    waitStart(1'b1);
    pushLeft(32'hA5A5_5A5A);
    waitStart(1'b0);
    captureSlot(lc, la);
    chk(la == 32'hA5A5_5A5A, "R8 left ok", la, 32'hA5A5_5A5A);
    chk(rightEmpty == 1'b1, "R8 empty kept", {31'd0, rightEmpty}, 32'd1);
    captureSlot(rc, ra);
    chk(ra == 32'd0, "R8 zero sample", ra, 32'd0);

    // R10 rate change inside a left half-frame waits for the next left start
    waitStart(1'b0);
    cfgRate = 2'd0;
    captureSlot(lc, la);
    captureSlot(rc, ra);
    chk(lc == 32 && rc == 32, "R10 old length kept", rc, 32);
    captureSlot(lc, la);
    chk(lc == 16, "R10 new length", lc, 16);

    // R6 sdata/lrck steady across rising sck: check over a few periods
    for (int k = 0; k < 20; k++) begin
      logic ps, pd, pl;
      @(negedge clk);
      ps = sck; pd = sdata; pl = lrck;
      @(negedge clk);
      if (!ps && sck) chk(sdata == pd && lrck == pl, "R6 rise stable", {30'd0, sdata, lrck}, {30'd0, pd, pl});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule